// File: doc/BRIEF.md
# Framed Serial Codec Port

This block is the device end of a synchronous framed serial link. From the system clock it derives a bit clock and a frame sync, and it drives both toward a host. In every frame one 16-bit sample word leaves the device and one 16-bit word arrives from the host. Both words move in the first 16 bit slots after the frame start, most significant bit first. The outgoing word is the converter sample, or zero while the converter is powered down. The incoming word is presented in parallel with a one-cycle valid strobe.

When the host sets the least significant bit of a data word, the port inserts a control frame. That frame starts 256 bit slots after the start of the requesting data frame, carries its own sync pulse, and leaves the spacing of data frames untouched. The incoming control word holds a read/write flag, a six-bit word address, a byte-select flag and a data byte. The port forwards these to an external register interface as a write strobe, or as a combinational read whose byte is returned in the low half of the outgoing control word.

The frame sequencer is a four-state machine. GAP covers the idle slots. DATA covers data bits 0 to 15. PEND waits for the control offset. CTRL covers control bits 0 to 15. The transitions are:

- GAP to DATA: the slot counter wraps to 0.
- DATA to PEND: slot 16 is reached and a request is held that fits the frame.
- DATA to GAP: slot 16 is reached and no request is held, or the request does not fit.
- PEND to CTRL: the slot counter reaches the control offset.
- CTRL to GAP: the slot counter reaches the control offset plus 16.

Top module: `fsp_port`

## Requirements
- R1: Each data frame shifts one 16-bit word out on `sdo` and one in from `sdi`, MSB first, in slots 0 to 15 after the frame start. The received word appears on `rx_sample` together with a one-system-clock `rx_valid` pulse.
- R2: `fsync` is high for exactly one bit-clock period, in the slot directly before bit 0 of a frame. The first sync comes in the first bit slot after reset.
- R3: `sdo` and `fsync` change only at rising edges of `bclk`, and `sdi` is sampled at falling edges.
- R4: Data frames repeat every `FRAME_BITS` slots (default 512). `sdo` is 0 in every slot outside the word fields, and `sdi` is ignored there.
- R5: A received data word with LSB 0 produces no control frame, so the next sync is the next data frame.
- R6: A received data word with LSB 1 produces a control frame whose sync is in slot `CTRL_OFS`-1 (default 255) of the same frame. The next data sync stays `FRAME_BITS` slots after the previous one.
- R7: The incoming control word is, from bit 15 down: bit 15 read flag (1 read, 0 write), bits 14:9 address bits 6:1 (address bit 0 is 0), bit 8 byte select (1 upper), bits 7:0 data. A write gives one `reg_we` pulse with `reg_addr`, `reg_byte_hi` and `reg_wdata`. A read gives no write.
- R8: The outgoing control word is `{8'h00, reg_rdata}` for a read, with the byte fetched at the addressed location. It is all zero for a write.
- R9: While `adc_pd` is high at the frame start, the outgoing data word is 0.
- R10: If `FRAME_BITS` < `CTRL_OFS`+17, a control request is ignored and no extra sync or register access follows. `err_short` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bclk | output | 1 | Bit clock, system clock divided by CLK_DIV |
| fsync | output | 1 | Frame sync pulse |
| sdo | output | 1 | Serial data to host |
| sdi | input | 1 | Serial data from host |
| adc_word | input | 16 | Sample word to send |
| adc_pd | input | 1 | Converter powered down, send zero |
| rx_sample | output | 16 | Last received data word |
| rx_valid | output | 1 | One-cycle strobe on a new rx_sample |
| reg_addr | output | 7 | Register address, bit 0 always 0 |
| reg_byte_hi | output | 1 | Byte select, 1 = upper byte |
| reg_re | output | 1 | Read fetch strobe |
| reg_rdata | input | 8 | Read byte, sampled in the same cycle as reg_re |
| reg_we | output | 1 | Write strobe |
| reg_wdata | output | 8 | Write byte |
| err_short | output | 1 | Sticky: control request did not fit the frame |

## Verification
Serial outputs take their new value in the system clock where `bclk` rises, so the bench reads `sdo` and `fsync` on the falling edge of `bclk` in the same slot. Words the device receives are registered in the system clock after the falling edge of slot 15. Control writes reach `reg_we` one system clock after the falling edge of the last control bit. For that reason the bench reads `rx_sample` and the write record only after the next rising `bclk` edge. Slot counts between syncs are taken on falling `bclk` edges: 240 from slot 16 to a control sync, and 496 to the next data sync when no control frame is inserted.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    localparam int WORD_W = 16;
    localparam int HDR_W  = 8;

    typedef enum logic [1:0] {
        ST_GAP  = 2'd0,
        ST_DATA = 2'd1,
        ST_PEND = 2'd2,
        ST_CTRL = 2'd3
    } fsp_state_e;
endpackage

// File: rtl/fsp_bitclk.sv
module fsp_bitclk #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic rise,
    output logic fall
);
    localparam int HALF = CLK_DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] TERM = HW'(HALF - 1);

    logic [HW-1:0] cnt_q;
    logic          tick;

    assign tick = (cnt_q == TERM);
    assign rise = tick & ~bclk;
    assign fall = tick & bclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bclk  <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            bclk  <= ~bclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fsp_frame_fsm.sv
module fsp_frame_fsm
    import fsp_pkg::*;
#(
    parameter int FRAME_BITS = 512,
    parameter int CTRL_OFS   = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic req,
    output logic fsync,
    output logic err_short,
    output logic start_data,
    output logic start_ctrl,
    output logic rd_load,
    output logic req_take,
    output logic cap_data,
    output logic cap_hdr,
    output logic cap_ctrl
);
    localparam int  PW      = $clog2(FRAME_BITS);
    localparam bit  CTRL_OK = (FRAME_BITS >= CTRL_OFS + WORD_W + 1);
    localparam logic [PW-1:0] P_LAST  = PW'(FRAME_BITS - 1);
    localparam logic [PW-1:0] P_WORD  = PW'(WORD_W);
    localparam logic [PW-1:0] P_CTRL  = PW'(CTRL_OK ? CTRL_OFS : 0);
    localparam logic [PW-1:0] P_CSYNC = PW'(CTRL_OK ? CTRL_OFS - 1 : 0);
    localparam logic [PW-1:0] P_HDR   = PW'(CTRL_OK ? CTRL_OFS + HDR_W : 0);
    localparam logic [PW-1:0] P_CEND  = PW'(CTRL_OK ? CTRL_OFS + WORD_W : 0);

    fsp_state_e    state_q, state_n;
    logic [PW-1:0] pos_q, pos_nx;

    assign pos_nx = (pos_q == P_LAST) ? '0 : pos_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GAP;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        if (rise) begin
            unique case (state_q)
                ST_GAP:  if (pos_nx == '0) state_n = ST_DATA;
                ST_DATA: if (pos_nx == P_WORD)
                             state_n = (req && CTRL_OK) ? ST_PEND : ST_GAP;
                ST_PEND: if (pos_nx == P_CTRL) state_n = ST_CTRL;
                ST_CTRL: if (pos_nx == P_CEND) state_n = ST_GAP;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q     <= P_LAST - 1'b1;
            fsync     <= 1'b0;
            err_short <= 1'b0;
        end else if (rise) begin
            pos_q <= pos_nx;
            fsync <= (pos_nx == P_LAST) ||
                     (state_q == ST_PEND && pos_nx == P_CSYNC);
            if (state_q == ST_DATA && pos_nx == P_WORD && req && !CTRL_OK)
                err_short <= 1'b1;
        end
    end

    // strobes for the data path
    assign start_data = rise && state_q == ST_GAP  && pos_nx == '0;
    assign start_ctrl = rise && state_q == ST_PEND && pos_nx == P_CTRL;
    assign rd_load    = rise && state_q == ST_CTRL && pos_nx == P_HDR;
    assign req_take   = rise && state_q == ST_DATA && pos_nx == P_WORD;
    assign cap_data   = state_q == ST_DATA && pos_q == P_WORD - 1'b1;
    assign cap_hdr    = state_q == ST_CTRL && pos_q == P_HDR  - 1'b1;
    assign cap_ctrl   = state_q == ST_CTRL && pos_q == P_CEND - 1'b1;
endmodule

// File: rtl/fsp_serdes.sv
module fsp_serdes
    import fsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    output logic              sdo,
    input  logic              start_data,
    input  logic              start_ctrl,
    input  logic              rd_load,
    input  logic              req_take,
    input  logic              cap_data,
    input  logic              cap_hdr,
    input  logic              cap_ctrl,
    input  logic [WORD_W-1:0] adc_word,
    input  logic              adc_pd,
    output logic [WORD_W-1:0] rx_sample,
    output logic              rx_valid,
    output logic              req,
    output logic [6:0]        reg_addr,
    output logic              reg_byte_hi,
    output logic              reg_re,
    input  logic [7:0]        reg_rdata,
    output logic              reg_we,
    output logic [7:0]        reg_wdata
);
    logic [WORD_W-1:0] out_sh, tx_word;
    logic [WORD_W-2:0] in_sh;
    logic [HDR_W-1:0]  hdr_q;
    logic [7:0]        rd_byte;
    logic [WORD_W-1:0] in_word;

    assign tx_word     = adc_pd ? '0 : adc_word;
    assign rd_byte     = hdr_q[7] ? reg_rdata : 8'h00;
    assign in_word     = {in_sh, sdi};
    assign reg_addr    = {hdr_q[6:1], 1'b0};
    assign reg_byte_hi = hdr_q[0];
    assign reg_re      = rd_load & hdr_q[7];

    // transmit side, rising bit-clock edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            out_sh <= '0;
        end else if (start_data) begin
            sdo    <= tx_word[WORD_W-1];
            out_sh <= {tx_word[WORD_W-2:0], 1'b0};
        end else if (start_ctrl) begin
            sdo    <= 1'b0;
            out_sh <= '0;
        end else if (rd_load) begin
            sdo    <= rd_byte[7];
            out_sh <= {rd_byte[6:0], {(WORD_W-7){1'b0}}};
        end else if (rise) begin
            sdo    <= out_sh[WORD_W-1];
            out_sh <= {out_sh[WORD_W-2:0], 1'b0};
        end
    end

    // receive side, falling bit-clock edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sh     <= '0;
            rx_sample <= '0;
            rx_valid  <= 1'b0;
            req       <= 1'b0;
            hdr_q     <= '0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            rx_valid <= 1'b0;
            reg_we   <= 1'b0;
            if (req_take) req <= 1'b0;
            if (fall) begin
                in_sh <= in_word[WORD_W-2:0];
                if (cap_data) begin
                    rx_sample <= in_word;
                    rx_valid  <= 1'b1;
                    req       <= sdi;
                end
                if (cap_hdr) hdr_q <= in_word[HDR_W-1:0];
                if (cap_ctrl && !hdr_q[7]) begin
                    reg_we    <= 1'b1;
                    reg_wdata <= in_word[7:0];
                end
            end
        end
    end
endmodule

// File: rtl/fsp_port.sv
module fsp_port
    import fsp_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int FRAME_BITS = 512,
    parameter int CTRL_OFS   = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        bclk,
    output logic        fsync,
    output logic        sdo,
    input  logic        sdi,
    input  logic [15:0] adc_word,
    input  logic        adc_pd,
    output logic [15:0] rx_sample,
    output logic        rx_valid,
    output logic [6:0]  reg_addr,
    output logic        reg_byte_hi,
    output logic        reg_re,
    input  logic [7:0]  reg_rdata,
    output logic        reg_we,
    output logic [7:0]  reg_wdata,
    output logic        err_short
);
    logic bit_rise, bit_fall, req;
    logic start_data, start_ctrl, rd_load, req_take;
    logic cap_data, cap_hdr, cap_ctrl;

    fsp_bitclk #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .rise(bit_rise), .fall(bit_fall)
    );

    fsp_frame_fsm #(.FRAME_BITS(FRAME_BITS), .CTRL_OFS(CTRL_OFS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(bit_rise), .req(req),
        .fsync(fsync), .err_short(err_short),
        .start_data(start_data), .start_ctrl(start_ctrl), .rd_load(rd_load),
        .req_take(req_take), .cap_data(cap_data), .cap_hdr(cap_hdr),
        .cap_ctrl(cap_ctrl)
    );

    fsp_serdes u_sd (
        .clk(clk), .rst_n(rst_n), .rise(bit_rise), .fall(bit_fall),
        .sdi(sdi), .sdo(sdo),
        .start_data(start_data), .start_ctrl(start_ctrl), .rd_load(rd_load),
        .req_take(req_take), .cap_data(cap_data), .cap_hdr(cap_hdr),
        .cap_ctrl(cap_ctrl), .adc_word(adc_word), .adc_pd(adc_pd),
        .rx_sample(rx_sample), .rx_valid(rx_valid), .req(req),
        .reg_addr(reg_addr), .reg_byte_hi(reg_byte_hi), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata)
    );
endmodule

// File: rtl/fsp_port_chk.sv
module fsp_port_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_rise,
    input logic fsync,
    input logic sdo,
    input logic reg_we,
    input logic reg_re,
    input logic err_short
);
    // R3
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> $stable(sdo));
    // R3
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> $stable(fsync));
    // R2
    sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_rise && fsync) |=> !fsync);
    // R7
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    // R8
    re_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> bit_rise);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_short |=> err_short);
endmodule

bind fsp_port fsp_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .fsync(fsync), .sdo(sdo),
    .reg_we(reg_we), .reg_re(reg_re), .err_short(err_short)
);

// File: tb/fsp_port_tb.sv
`timescale 1ns/1ps
module fsp_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        bclk, fsync, sdo, sdi, adc_pd, rx_valid, reg_byte_hi, reg_re, reg_we, err_short;
    logic [15:0] adc_word, rx_sample;
    logic [6:0]  reg_addr;
    logic [7:0]  reg_rdata, reg_wdata;
    logic [7:0]  mem_lo [64];
    logic [7:0]  mem_hi [64];
    int          we_cnt = 0;
    int          checks = 0, fails = 0;
    bit          gap_level = 1'b0;

    logic        s_bclk, s_fsync, s_sdo, s_rxv, s_hi, s_re, s_we, s_err;
    logic        s_sdi = 1'b1;
    logic [15:0] s_rx;
    logic [6:0]  s_addr;
    logic [7:0]  s_wd;
    int          s_we_cnt = 0;

    assign reg_rdata = reg_byte_hi ? mem_hi[reg_addr[6:1]] : mem_lo[reg_addr[6:1]];

    fsp_port u_dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdo(sdo), .sdi(sdi),
        .adc_word(adc_word), .adc_pd(adc_pd), .rx_sample(rx_sample), .rx_valid(rx_valid),
        .reg_addr(reg_addr), .reg_byte_hi(reg_byte_hi), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata), .err_short(err_short)
    );

    fsp_port #(.FRAME_BITS(64)) u_dut_short (
        .clk(clk), .rst_n(rst_n), .bclk(s_bclk), .fsync(s_fsync), .sdo(s_sdo), .sdi(s_sdi),
        .adc_word(16'h1111), .adc_pd(1'b0), .rx_sample(s_rx), .rx_valid(s_rxv),
        .reg_addr(s_addr), .reg_byte_hi(s_hi), .reg_re(s_re),
        .reg_rdata(8'h00), .reg_we(s_we), .reg_wdata(s_wd), .err_short(s_err)
    );

    always @(posedge clk) begin
        if (reg_we) begin
            we_cnt <= we_cnt + 1;
            if (reg_byte_hi) mem_hi[reg_addr[6:1]] <= reg_wdata;
            else             mem_lo[reg_addr[6:1]] <= reg_wdata;
        end
        if (s_we || s_re) s_we_cnt <= s_we_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_sync(output int n, output bit saw_one);
        n = 0; saw_one = 1'b0;
        do begin
            @(negedge bclk);
            n++;
            if (!fsync && sdo) saw_one = 1'b1;
        end while (!fsync);
    endtask

    task automatic xfer(input logic [15:0] hin, output logic [15:0] dout);
        for (int i = 15; i >= 0; i--) begin
            @(posedge bclk); #1 sdi = hin[i];
            @(negedge bclk); dout[i] = sdo;
        end
        @(posedge bclk); #1 sdi = gap_level;
    endtask

    // data frame: word exchange, received word, then gap to next sync
    task automatic t_data(input logic [15:0] hin, input logic [15:0] aw, input bit pd,
                          input logic [15:0] exp_out, input string tag);
        logic [15:0] d; int n; bit s;
        adc_word = aw; adc_pd = pd;
        xfer(hin, d);
        chk(d == exp_out, {tag, " sdo word"}, d, exp_out);
        chk(rx_sample == hin, "R1 rx_sample", rx_sample, hin);
        wait_sync(n, s);
        chk(n == 496, "R5 R4 slots to next data sync", n, 496);
        chk(!s, "R4 sdo zero in gap", s, 0);
        chk(rx_sample == hin, "R4 gap input ignored", rx_sample, hin);
    endtask

    // data frame requesting a control frame, then the control word
    task automatic t_ctrl(input logic [15:0] cword, input logic [15:0] exp_ctrl, input string tag);
        logic [15:0] d; int n; bit s;
        adc_word = 16'h6C31; adc_pd = 1'b0;
        xfer(16'h2469, d);
        chk(d == 16'h6C31, "R1 data word before control", d, 16'h6C31);
        wait_sync(n, s);
        chk(n == 240, "R6 control sync offset", n, 240);
        chk(!s, "R4 sdo zero before control", s, 0);
        xfer(cword, d);
        chk(d == exp_ctrl, {tag, " control out word"}, d, exp_ctrl);
        wait_sync(n, s);
        chk(n == 240, "R6 data spacing kept", n, 240);
    endtask

    task automatic t_write(input logic [6:0] a, input bit hi, input logic [7:0] v);
        int w0 = we_cnt;
        t_ctrl({1'b0, a[6:1], hi, v}, 16'h0000, "R8 write");
        chk(we_cnt == w0 + 1, "R7 one write strobe", we_cnt, w0 + 1);
        if (hi) chk(mem_hi[a[6:1]] == v, "R7 upper byte written", mem_hi[a[6:1]], v);
        else    chk(mem_lo[a[6:1]] == v, "R7 lower byte written", mem_lo[a[6:1]], v);
    endtask

    task automatic t_read(input logic [6:0] a, input bit hi);
        int w0 = we_cnt;
        logic [7:0] e = hi ? mem_hi[a[6:1]] : mem_lo[a[6:1]];
        t_ctrl({1'b1, a[6:1], hi, 8'hA7}, {8'h00, e}, "R8 read");
        chk(we_cnt == w0, "R7 read makes no write", we_cnt, w0);
    endtask

    task automatic t_reset;
        chk(fsync == 0 && sdo == 0, "R2 reset sync/sdo low", {fsync, sdo}, 0);
        chk(rx_valid == 0 && reg_we == 0 && err_short == 0, "R10 reset strobes/err low",
            {rx_valid, reg_we, err_short}, 0);
    endtask

    task automatic t_short;
        time t0, t1;
        chk(s_err == 1'b1, "R10 err_short set", s_err, 1);
        chk(s_we_cnt == 0, "R10 no register access", s_we_cnt, 0);
        for (int k = 0; k < 3; k++) begin
            @(posedge s_fsync); t0 = $time;
            @(posedge s_fsync); t1 = $time;
            chk(t1 - t0 == 2560, "R10 no extra sync in short frame", t1 - t0, 2560);
        end
        s_sdi = 1'b0;
        repeat (800) @(posedge clk);
        chk(s_err == 1'b1, "R10 err_short sticky", s_err, 1);
        chk(err_short == 1'b0, "R10 long frame no error", err_short, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n; bit s;
        for (int i = 0; i < 64; i++) begin
            mem_lo[i] = 8'(i * 5 + 3);
            mem_hi[i] = 8'(8'hF0 ^ i);
        end
        sdi = 0; adc_word = 16'h0; adc_pd = 0;
        repeat (6) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        wait_sync(n, s);
        chk(n == 1, "R2 first sync slot", n, 1);
        t_data(16'h1234, 16'hA55A, 1'b0, 16'hA55A, "R1");
        t_data(16'hFFFE, 16'h8001, 1'b1, 16'h0000, "R9 powered down");
        gap_level = 1'b1;
        t_data(16'h0F0E, 16'h7E81, 1'b0, 16'h7E81, "R3");
        gap_level = 1'b0;
        t_write(7'h10, 1'b0, 8'hC3);
        t_read(7'h10, 1'b0);
        t_read(7'h2A, 1'b1);
        t_write(7'h2A, 1'b1, 8'h5D);
        t_read(7'h2A, 1'b1);
        t_data(16'h4442, 16'h0001, 1'b0, 16'h0001, "R5");
        t_short();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule